// File: doc/BRIEF.md
# Burst Low-Address Sequencer

This block produces the word address for a burst memory access of up to four beats. A start address is captured on a load cycle. On each later advance cycle the two least significant address bits move through a four-word group. The upper address bits stay as they were captured. The order of the low bits is picked on each load. It is either a wrapping linear count or an order where the start bits are XORed with the beat number.

Control is a single advance/load strobe and an active-low clock enable. When the clock enable is deasserted, every register keeps its value and both load and advance requests are dropped. An advance does not depend on any select or write-direction signal. The only inputs that gate it are the strobe and the clock enable. The address out is a combinational function of the registers, so the first beat appears in the cycle right after the load edge.

The core is a four-state beat machine with states BEAT0, BEAT1, BEAT2 and BEAT3. It has four transitions:
- LOAD: any state goes to BEAT0.
- STEP: BEATn goes to BEATn+1.
- WRAP: BEAT3 goes to BEAT0 on an advance.
- HOLD: the state stays the same when the clock enable is high.

Top module: `burst_addr_ctr`

## Requirements
- R1: While `rst_n` is low, `addr_out` is zero. The machine is in BEAT0 with linear order, so the first advance after reset gives 1.
- R2: A qualified edge (`clk_en_n` = 0) with `adv_ld` = 0 captures `addr_in`. `addr_out` equals that value after the edge.
- R3: An edge with `clk_en_n` = 1 changes nothing: the address, beat and order stay the same, whatever `adv_ld`, `order_sel` and `addr_in` are.
- R4: A qualified edge with `adv_ld` = 1 leaves `addr_out[AW-1:2]` equal to the value it had before the edge.
- R5: With linear order (`order_sel` = 0 at load), beat n outputs low bits equal to (start + n) mod 4. For example, a start of 2 gives 2, 3, 0, 1.
- R6: With interleaved order (`order_sel` = 1 at load), beat n outputs low bits equal to start XOR n. For example, a start of 1 gives 1, 0, 3, 2.
- R7: An advance from the fourth beat returns to the first beat, so the sequence repeats.
- R8: The order is captured only on a load. A change of `order_sel` during advances has no effect.
- R9: `addr_in` is ignored on advance cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en_n | input | 1 | Clock qualifier, active low; high holds all state |
| adv_ld | input | 1 | 0 = load start address, 1 = advance one beat |
| order_sel | input | 1 | Order for the burst being loaded: 0 linear, 1 interleaved |
| addr_in | input | AW | Start address, sampled on load |
| addr_out | output | AW | Current word address to the array |

## Verification
The hardest cases to reach are those where a control input changes in the middle of a burst. One is `order_sel` flipping between two advances. The other is a load request that arrives while the clock enable is high. The stimulus table places both inside a running interleaved burst. At those points a linear step and an interleaved step give different low bits, and the start address differs from the current one, so a wrongly taken load or order switch changes the address seen at the port. A reset asserted in the middle of a burst, followed by a single advance, shows that the beat and order registers go back to their start values and not just the address.

// File: rtl/burst_ctr_pkg.sv
package burst_ctr_pkg;

    localparam int SEQ_W = 2;

    typedef enum logic [1:0] {
        BEAT0 = 2'd0,
        BEAT1 = 2'd1,
        BEAT2 = 2'd2,
        BEAT3 = 2'd3
    } beat_e;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } order_e;

    // Successor of a beat; BEAT3 wraps to BEAT0.
    function automatic beat_e beat_succ(input beat_e b);
        beat_e n;
        unique case (b)
            BEAT0:   n = BEAT1;
            BEAT1:   n = BEAT2;
            BEAT2:   n = BEAT3;
            BEAT3:   n = BEAT0;
            default: n = BEAT0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/burst_beat_fsm.sv
module burst_beat_fsm
    import burst_ctr_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clk_en_n,
    input  logic          adv_ld,
    input  logic          order_sel,
    input  logic [AW-1:0] addr_in,
    output beat_e         beat,
    output order_e        order,
    output logic [AW-1:0] base
);

    beat_e          beat_q, beat_d;
    order_e         order_q, order_d;
    logic [AW-1:0]  base_q, base_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q  <= BEAT0;
            order_q <= ORD_LINEAR;
            base_q  <= '0;
        end else begin
            beat_q  <= beat_d;
            order_q <= order_d;
            base_q  <= base_d;
        end
    end

    // Next-state: HOLD, LOAD, STEP / WRAP
    always_comb begin
        beat_d  = beat_q;
        order_d = order_q;
        base_d  = base_q;
        if (!clk_en_n) begin
            if (!adv_ld) begin
                beat_d  = BEAT0;
                order_d = order_e'(order_sel);
                base_d  = addr_in;
            end else begin
                unique case (beat_q)
                    BEAT0, BEAT1, BEAT2: beat_d = beat_succ(beat_q);
                    BEAT3:               beat_d = BEAT0;
                    default:             beat_d = BEAT0;
                endcase
            end
        end
    end

    assign beat  = beat_q;
    assign order = order_q;
    assign base  = base_q;

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_ctr_pkg::*;
(
    input  logic [SEQ_W-1:0] start_lo,
    input  beat_e            beat,
    input  order_e           order,
    output logic [SEQ_W-1:0] seq_lo
);

    logic [SEQ_W-1:0] lin_lo;
    logic [SEQ_W-1:0] xor_lo;

    assign lin_lo = start_lo + SEQ_W'(beat);
    assign xor_lo = start_lo ^ SEQ_W'(beat);

    always_comb begin
        unique case (order)
            ORD_LINEAR: seq_lo = lin_lo;
            ORD_XOR:    seq_lo = xor_lo;
            default:    seq_lo = lin_lo;
        endcase
    end

endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
    import burst_ctr_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clk_en_n,
    input  logic          adv_ld,
    input  logic          order_sel,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_out
);

    localparam int HI_W = AW - SEQ_W;

    beat_e            beat_w;
    order_e           order_w;
    logic [AW-1:0]    base_w;
    logic [SEQ_W-1:0] seq_lo_w;

    burst_beat_fsm #(.AW(AW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en_n  (clk_en_n),
        .adv_ld    (adv_ld),
        .order_sel (order_sel),
        .addr_in   (addr_in),
        .beat      (beat_w),
        .order     (order_w),
        .base      (base_w)
    );

    burst_order_map u_map (
        .start_lo (base_w[SEQ_W-1:0]),
        .beat     (beat_w),
        .order    (order_w),
        .seq_lo   (seq_lo_w)
    );

    generate
        if (HI_W > 0) begin : g_hi
            assign addr_out = {base_w[AW-1:SEQ_W], seq_lo_w};
        end else begin : g_lo_only
            assign addr_out = seq_lo_w[AW-1:0];
        end
    endgenerate

endmodule

// File: rtl/burst_addr_ctr_chk.sv
module burst_addr_ctr_chk
    import burst_ctr_pkg::*;
#(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clk_en_n,
    input logic          adv_ld,
    input logic [AW-1:0] addr_in,
    input logic [AW-1:0] addr_out,
    input beat_e         beat,
    input order_e        order
);

    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !adv_ld) |=> addr_out == $past(addr_in));

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> ($stable(addr_out) && $stable(beat) && $stable(order)));

    a_r4_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && adv_ld) |=> addr_out[AW-1:SEQ_W] == $past(addr_out[AW-1:SEQ_W]));

    a_r5_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && adv_ld && order == ORD_LINEAR)
            |=> addr_out[SEQ_W-1:0] == $past(addr_out[SEQ_W-1:0]) + 2'd1);

    a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && adv_ld && beat == BEAT3) |=> beat == BEAT0);

    a_r8_order_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en_n || adv_ld) |=> $stable(order));

endmodule

bind burst_addr_ctr burst_addr_ctr_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en_n (clk_en_n),
    .adv_ld   (adv_ld),
    .addr_in  (addr_in),
    .addr_out (addr_out),
    .beat     (beat_w),
    .order    (order_w)
);

// File: tb/burst_addr_ctr_tb.sv
`timescale 1ns/1ps
module burst_addr_ctr_tb;

    localparam int AW = 16;
    localparam int VW = 4 + 3 + 2 * AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en_n = 1'b1;
    logic          adv_ld = 1'b0;
    logic          order_sel = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    burst_addr_ctr #(.AW(AW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en_n  (clk_en_n),
        .adv_ld    (adv_ld),
        .order_sel (order_sel),
        .addr_in   (addr_in),
        .addr_out  (addr_out)
    );

    // {req, clk_en_n, adv_ld, order_sel, addr_in, expected addr_out}
    localparam int NV = 21;
    localparam logic [VW-1:0] VEC [NV] = '{
        {4'd2, 3'b000, 16'h1232, 16'h1232},  // R2 load, linear
        {4'd5, 3'b010, 16'h0000, 16'h1233},  // R5
        {4'd5, 3'b010, 16'h0000, 16'h1230},  // R5 wrap in group
        {4'd4, 3'b010, 16'h0000, 16'h1231},  // R4 upper kept
        {4'd7, 3'b010, 16'h0000, 16'h1232},  // R7 repeat
        {4'd2, 3'b001, 16'hABC1, 16'hABC1},  // R2 load, interleaved
        {4'd9, 3'b010, 16'hFFFF, 16'hABC0},  // R9 addr ignored
        {4'd3, 3'b110, 16'h0000, 16'hABC0},  // R3 hold on advance
        {4'd6, 3'b011, 16'h0000, 16'hABC3},  // R6
        {4'd6, 3'b011, 16'h0000, 16'hABC2},  // R6
        {4'd7, 3'b011, 16'h0000, 16'hABC1},  // R7 wrap
        {4'd8, 3'b010, 16'h0000, 16'hABC0},  // R8 order flip ignored
        {4'd3, 3'b100, 16'h0000, 16'hABC0},  // R3 load ignored
        {4'd8, 3'b010, 16'h0000, 16'hABC3},  // R8 still interleaved
        {4'd2, 3'b000, 16'h00FF, 16'h00FF},  // R2
        {4'd4, 3'b010, 16'h0000, 16'h00FC},  // R4 no carry into upper
        {4'd2, 3'b001, 16'h5552, 16'h5552},  // R2
        {4'd6, 3'b011, 16'h0000, 16'h5553},  // R6
        {4'd6, 3'b011, 16'h0000, 16'h5550},  // R6
        {4'd6, 3'b011, 16'h0000, 16'h5551},  // R6
        {4'd7, 3'b011, 16'h0000, 16'h5552}   // R7
    };

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: addr_out=%h expected %h", req, act, exp);
        end
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1;
        check("R1", addr_out, 16'h0000);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R1: first advance after reset, base 0 linear
        @(negedge clk);
        clk_en_n = 1'b0; adv_ld = 1'b1;
        @(posedge clk); #1;
        check("R1", addr_out, 16'h0001);

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            @(negedge clk);
            clk_en_n  = v[2*AW+2];
            adv_ld    = v[2*AW+1];
            order_sel = v[2*AW];
            addr_in   = v[2*AW-1:AW];
            @(posedge clk); #1;
            check($sformatf("R%0d", v[VW-1:VW-4]), addr_out, v[AW-1:0]);
        end

        // R1: reset mid-burst clears beat and order as well
        @(negedge clk);
        clk_en_n = 1'b0; adv_ld = 1'b0; order_sel = 1'b1; addr_in = 16'h7775;
        @(posedge clk); #1;
        adv_ld = 1'b1;
        @(posedge clk); #1;
        check("R6", addr_out, 16'h7774);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1", addr_out, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1; order_sel = 1'b1;
        @(posedge clk); #1;
        check("R1", addr_out, 16'h0001);
        @(posedge clk); #1;
        check("R1", addr_out, 16'h0002);

        // R3: hold for several cycles with changing inputs
        @(negedge clk);
        clk_en_n = 1'b1; adv_ld = 1'b0; addr_in = 16'h1111;
        repeat (3) @(posedge clk);
        #1;
        check("R3", addr_out, 16'h0002);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule